// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

The block is a memory-mapped mailbox between a host processor and an embedded controller. The host uses a simple 32-bit register bus. It fills a 16-byte payload buffer and then writes a command word. Writing the command word latches the command, sets a busy flag and sends a one-cycle doorbell to the controller. The controller reads the latched command and the payload on its own port. It writes up to 16 bytes of response into a read buffer and ends the transaction with a single-cycle done strobe, which carries an error flag and an 8-bit error code.

Busy stays set until that done strobe arrives. The host then reads the status word and the response, either as 32-bit words or as single bytes. If the command word asked for a completion interrupt, completion raises an interrupt-pending status bit and drives a one-cycle pulse on the host interrupt line. The host clears the pending bit by writing the status register with bit 2 set. The same command layout carries power-register requests (code 0xFF with sub-command 0 write, 1 read, 2 masked update). The mailbox passes these through without interpreting them.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, busy, error and interrupt-pending are 0, the host interrupt and doorbell are low, the controller-visible payload is all zero, and every response word reads 0.
- R2: A host write to offset 0x00 while not busy latches the word onto `c_cmd_o`, sets busy (status bit 0), and drives `c_doorbell_o` high for exactly the one cycle after the write edge. Command word layout: bits 31:24 reserved, 23:16 size, 15:12 sub-command, 11:9 reserved, bit 8 interrupt-on-completion, 7:0 command code.
- R3: While busy, a host write to offset 0x00 is ignored: no doorbell, and `c_cmd_o` is unchanged. Host payload writes are also ignored while busy, so `c_wbuf_o` is unchanged.
- R4: A host word write to offset 0x80+4k (k=0..3) while idle lands in bits [32k+31:32k] of `c_wbuf_o`.
- R5: Busy stays 1 until a controller done strobe. On done, busy clears, status bit 1 takes `c_err_i` and status bits 23:16 take `c_err_code_i`. Status bits 7:4 show the sub-command of the last accepted command. Accepting a new command clears the error bit and the error code.
- R6: If bit 8 of the accepted command was 1, done sets status bit 2 and pulses `h_irq_o` high for exactly the cycle after the done edge. If bit 8 was 0, there is no pulse and bit 2 is not set.
- R7: A host write to offset 0x04 with bit 2 set clears interrupt-pending. A write to that offset with bit 2 clear leaves it unchanged.
- R8: A controller response write while busy stores `c_rsp_data_i` into response word `c_rsp_idx_i`. A host word read at 0x90+4k returns word k. A byte read (`h_byte_i`=1) at 0x90+n returns byte n mod 4 of word n/4, in little-endian order, zero-extended.
- R9: Response writes and done strobes that arrive while not busy are ignored. The response buffer and the status word stay unchanged, and no interrupt pulse occurs.
- R10: Status bits 15:8 always read the INIT_ID parameter (default 0x01). Bit 3 and bits 31:24 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| h_addr_i | input | 8 | Host byte address |
| h_wr_i | input | 1 | Host write strobe |
| h_wdata_i | input | 32 | Host write data |
| h_rd_i | input | 1 | Host read strobe |
| h_byte_i | input | 1 | Host read is a byte read |
| h_rdata_o | output | 32 | Host read data (combinational) |
| h_irq_o | output | 1 | Completion interrupt pulse |
| c_doorbell_o | output | 1 | Doorbell pulse to controller |
| c_cmd_o | output | 32 | Latched command word |
| c_wbuf_o | output | 128 | Payload buffer contents |
| c_rsp_we_i | input | 1 | Response word write |
| c_rsp_idx_i | input | 2 | Response word index |
| c_rsp_data_i | input | 32 | Response word data |
| c_done_i | input | 1 | Single-cycle completion strobe |
| c_err_i | input | 1 | Completion error flag |
| c_err_code_i | input | 8 | Completion error code |

## Verification
The bench sends a second command and a payload write while the first command is still in flight. A design that does not guard on busy would ring the doorbell again, overwrite the latched command or corrupt the payload. It also sends done strobes and response writes while idle, which a loose design would let set error state, fire an interrupt or change the response. Completion is tested with the interrupt flag both set and clear, and with and without an error. This catches an interrupt that fires regardless of the flag, a pulse that lasts more than one cycle, and a stale error bit left over from the previous command. Byte reads at non-zero lanes check the byte order. Status writes with bit 2 clear check that pending is cleared only by that bit.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
  typedef struct packed {
    logic [7:0] rsvd_hi;
    logic [7:0] size;
    logic [3:0] sub;
    logic [2:0] rsvd_lo;
    logic       ioc;
    logic [7:0] code;
  } cmd_t;

  localparam int STAT_BUSY = 0;
  localparam int STAT_ERR  = 1;
  localparam int STAT_PEND = 2;
  localparam int WORD_W    = 32;
endpackage

// File: rtl/ipc_buf.sv
module ipc_buf #(
  parameter int WORDS = 4,
  parameter int IDX_W = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [31:0]          data_i,
  output logic [WORDS*32-1:0]  flat_o
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   flat_o[w*32 +: 32] <= '0;
      else if (we_i && idx_i == IDX_W'(w))            flat_o[w*32 +: 32] <= data_i;
    end
  end
endmodule

// File: rtl/ipc_ctrl.sv
module ipc_ctrl
  import ipc_mbox_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_we_i,
  input  logic        stat_we_i,
  input  logic [31:0] wdata_i,
  input  logic        done_i,
  input  logic        err_i,
  input  logic [7:0]  err_code_i,
  output cmd_t        cmd_o,
  output logic        busy_o,
  output logic        err_o,
  output logic        pend_o,
  output logic [7:0]  code_o,
  output logic        doorbell_o,
  output logic        irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o      <= '0;
      busy_o     <= 1'b0;
      err_o      <= 1'b0;
      pend_o     <= 1'b0;
      code_o     <= '0;
      doorbell_o <= 1'b0;
      irq_o      <= 1'b0;
    end else begin
      doorbell_o <= 1'b0;
      irq_o      <= 1'b0;
      // ack first so a same-cycle completion wins
      if (stat_we_i && wdata_i[STAT_PEND]) pend_o <= 1'b0;
      if (cmd_we_i && !busy_o) begin
        cmd_o      <= cmd_t'(wdata_i);
        busy_o     <= 1'b1;
        err_o      <= 1'b0;
        code_o     <= '0;
        doorbell_o <= 1'b1;
      end else if (done_i && busy_o) begin
        busy_o <= 1'b0;
        err_o  <= err_i;
        code_o <= err_code_i;
        if (cmd_o.ioc) begin
          pend_o <= 1'b1;
          irq_o  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mbox_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter int         BUF_BYTES = 16,
  parameter logic [7:0] INIT_ID   = 8'h01,
  localparam int        BUF_WORDS = BUF_BYTES / 4,
  localparam int        IDX_W     = $clog2(BUF_WORDS),
  localparam int        BUF_W     = BUF_WORDS * 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] h_addr_i,
  input  logic              h_wr_i,
  input  logic [31:0]       h_wdata_i,
  input  logic              h_rd_i,
  input  logic              h_byte_i,
  output logic [31:0]       h_rdata_o,
  output logic              h_irq_o,
  output logic              c_doorbell_o,
  output logic [31:0]       c_cmd_o,
  output logic [BUF_W-1:0]  c_wbuf_o,
  input  logic              c_rsp_we_i,
  input  logic [IDX_W-1:0]  c_rsp_idx_i,
  input  logic [31:0]       c_rsp_data_i,
  input  logic              c_done_i,
  input  logic              c_err_i,
  input  logic [7:0]        c_err_code_i
);
  localparam logic [ADDR_W-1:0] CMD_OFS  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] WBUF_OFS = ADDR_W'(8'h80);
  localparam logic [ADDR_W-1:0] RBUF_OFS = ADDR_W'(8'h90);
  localparam logic [ADDR_W-1:0] SPAN     = ADDR_W'(BUF_BYTES);

  cmd_t             cmd_q;
  logic             busy, err, pend;
  logic [7:0]       code;
  logic [BUF_W-1:0] rbuf;
  logic             in_wbuf, in_rbuf;
  logic [IDX_W-1:0] word_idx;
  logic [31:0]      rword, status;

  assign in_wbuf  = h_addr_i >= WBUF_OFS && h_addr_i < WBUF_OFS + SPAN;
  assign in_rbuf  = h_addr_i >= RBUF_OFS && h_addr_i < RBUF_OFS + SPAN;
  assign word_idx = h_addr_i[IDX_W+1:2];

  ipc_ctrl u_ctrl (
    .clk_i,
    .rst_ni,
    .cmd_we_i   (h_wr_i && h_addr_i == CMD_OFS),
    .stat_we_i  (h_wr_i && h_addr_i == STAT_OFS),
    .wdata_i    (h_wdata_i),
    .done_i     (c_done_i),
    .err_i      (c_err_i),
    .err_code_i (c_err_code_i),
    .cmd_o      (cmd_q),
    .busy_o     (busy),
    .err_o      (err),
    .pend_o     (pend),
    .code_o     (code),
    .doorbell_o (c_doorbell_o),
    .irq_o      (h_irq_o)
  );

  ipc_buf #(.WORDS(BUF_WORDS), .IDX_W(IDX_W)) u_wbuf (
    .clk_i,
    .rst_ni,
    .we_i   (h_wr_i && in_wbuf && !busy),
    .idx_i  (word_idx),
    .data_i (h_wdata_i),
    .flat_o (c_wbuf_o)
  );

  ipc_buf #(.WORDS(BUF_WORDS), .IDX_W(IDX_W)) u_rbuf (
    .clk_i,
    .rst_ni,
    .we_i   (c_rsp_we_i && busy),
    .idx_i  (c_rsp_idx_i),
    .data_i (c_rsp_data_i),
    .flat_o (rbuf)
  );

  assign c_cmd_o = cmd_q;
  assign status  = {8'h00, code, INIT_ID, cmd_q.sub, 1'b0, pend, err, busy};
  assign rword   = rbuf[word_idx*32 +: 32];

  always_comb begin
    h_rdata_o = '0;
    if (h_rd_i) begin
      if (h_addr_i == STAT_OFS) h_rdata_o = status;
      else if (in_rbuf) h_rdata_o = h_byte_i ? {24'h0, rword[h_addr_i[1:0]*8 +: 8]} : rword;
    end
  end
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] h_addr_i,
  input logic              h_wr_i,
  input logic [31:0]       h_wdata_i,
  input logic              doorbell_i,
  input logic              irq_i,
  input logic              busy_i,
  input logic              pend_i,
  input logic              done_i
);
  logic ack;
  assign ack = h_wr_i && h_addr_i == ADDR_W'(8'h04) && h_wdata_i[2];

  a_r2_doorbell_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    doorbell_i |=> !doorbell_i);
  a_r2_doorbell_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    doorbell_i |-> busy_i);
  a_r3_doorbell_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    doorbell_i |-> !$past(busy_i));
  a_r5_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !done_i |=> busy_i);
  a_r6_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> !irq_i);
  a_r6_irq_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> $past(done_i) && $past(busy_i) && !busy_i);
  a_r6_irq_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> pend_i);
  a_r7_pend_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_i && !ack |=> pend_i);
endmodule

bind ipc_mailbox ipc_mailbox_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .h_addr_i   (h_addr_i),
  .h_wr_i     (h_wr_i),
  .h_wdata_i  (h_wdata_i),
  .doorbell_i (c_doorbell_o),
  .irq_i      (h_irq_o),
  .busy_i     (busy),
  .pend_i     (pend),
  .done_i     (c_done_i)
);

// File: tb/tb_ipc_mailbox.sv
`timescale 1ns/1ps
module tb_ipc_mailbox;
  logic         clk_i = 1'b0, rst_ni = 1'b0;
  logic [7:0]   h_addr_i = '0;
  logic         h_wr_i = 1'b0, h_rd_i = 1'b0, h_byte_i = 1'b0;
  logic [31:0]  h_wdata_i = '0, h_rdata_o;
  logic         h_irq_o, c_doorbell_o;
  logic [31:0]  c_cmd_o;
  logic [127:0] c_wbuf_o;
  logic         c_rsp_we_i = 1'b0, c_done_i = 1'b0, c_err_i = 1'b0;
  logic [1:0]   c_rsp_idx_i = '0;
  logic [31:0]  c_rsp_data_i = '0;
  logic [7:0]   c_err_code_i = '0;

  int total = 0, bad = 0;
  logic [31:0] rd;

  always #10 clk_i = ~clk_i;

  ipc_mailbox dut (.*);

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i); h_addr_i = a; h_wdata_i = d; h_wr_i = 1'b1;
    @(negedge clk_i); h_wr_i = 1'b0;
  endtask

  task automatic host_rd(logic [7:0] a, logic b, output logic [31:0] d);
    @(negedge clk_i); h_addr_i = a; h_byte_i = b; h_rd_i = 1'b1;
    #2 d = h_rdata_o;
    h_rd_i = 1'b0; h_byte_i = 1'b0;
  endtask

  task automatic rsp_wr(logic [1:0] i, logic [31:0] d);
    @(negedge clk_i); c_rsp_idx_i = i; c_rsp_data_i = d; c_rsp_we_i = 1'b1;
    @(negedge clk_i); c_rsp_we_i = 1'b0;
  endtask

  task automatic ctl_done(logic e, logic [7:0] c);
    @(negedge clk_i); c_err_i = e; c_err_code_i = c; c_done_i = 1'b1;
    @(negedge clk_i); c_done_i = 1'b0;
  endtask

  task automatic t_reset;
    host_rd(8'h04, 1'b0, rd);
    chk("R1 status", rd, 32'h0000_0100);
    chk("R10 init id", rd[15:8], 8'h01);
    chk("R1 wbuf", c_wbuf_o, '0);
    host_rd(8'h9C, 1'b0, rd);
    chk("R1 rbuf", rd, 0);
    chk("R1 irq/doorbell", {h_irq_o, c_doorbell_o}, 0);
  endtask

  task automatic t_payload;
    for (int k = 0; k < 4; k++) host_wr(8'h80 + 8'(4*k), 32'h1000_0000 + k);
    chk("R4 wbuf", c_wbuf_o, {32'h1000_0003, 32'h1000_0002, 32'h1000_0001, 32'h1000_0000});
  endtask

  task automatic t_cmd;
    host_wr(8'h00, 32'h0004_11FF);
    chk("R2 doorbell high", c_doorbell_o, 1);
    chk("R2 cmd latched", c_cmd_o, 32'h0004_11FF);
    @(negedge clk_i);
    chk("R2 doorbell one cycle", c_doorbell_o, 0);
    host_rd(8'h04, 1'b0, rd);
    chk("R2 busy", rd[0], 1);
    chk("R5 cmd id", rd[7:4], 4'h1);
  endtask

  task automatic t_busy_ignore;
    host_wr(8'h00, 32'h0002_2000);
    chk("R3 no doorbell", c_doorbell_o, 0);
    chk("R3 cmd kept", c_cmd_o, 32'h0004_11FF);
    host_wr(8'h80, 32'hBAD0_BAD0);
    chk("R3 wbuf kept", c_wbuf_o[31:0], 32'h1000_0000);
  endtask

  task automatic t_resp;
    rsp_wr(2'd0, 32'hA1B2_C3D4);
    rsp_wr(2'd3, 32'h1122_3344);
    repeat (5) @(negedge clk_i);
    host_rd(8'h04, 1'b0, rd);
    chk("R5 busy held", rd[0], 1);
    ctl_done(1'b0, 8'h5A);
    chk("R6 irq pulse", h_irq_o, 1);
    host_rd(8'h04, 1'b0, rd);
    chk("R6 irq one cycle", h_irq_o, 0);
    chk("R5 R6 status", rd, 32'h005A_0114);
    host_rd(8'h90, 1'b0, rd);
    chk("R8 word0", rd, 32'hA1B2_C3D4);
    host_rd(8'h91, 1'b1, rd);
    chk("R8 byte1", rd, 32'h0000_00C3);
    host_rd(8'h9F, 1'b1, rd);
    chk("R8 byte15", rd, 32'h0000_0011);
    host_rd(8'h9C, 1'b0, rd);
    chk("R8 word3", rd, 32'h1122_3344);
  endtask

  task automatic t_ack;
    host_wr(8'h04, 32'hFFFF_FFFB);
    host_rd(8'h04, 1'b0, rd);
    chk("R7 pend kept", rd[2], 1);
    host_wr(8'h04, 32'h0000_0004);
    host_rd(8'h04, 1'b0, rd);
    chk("R7 pend cleared", rd[2], 0);
  endtask

  task automatic t_err_noioc;
    host_wr(8'h00, 32'h0003_2042);
    chk("R2 doorbell second", c_doorbell_o, 1);
    ctl_done(1'b1, 8'h33);
    chk("R6 no irq", h_irq_o, 0);
    host_rd(8'h04, 1'b0, rd);
    chk("R5 err status", rd, 32'h0033_0122);
  endtask

  task automatic t_idle_ignore;
    rsp_wr(2'd0, 32'hDEAD_BEEF);
    host_rd(8'h90, 1'b0, rd);
    chk("R9 rbuf kept", rd, 32'hA1B2_C3D4);
    ctl_done(1'b0, 8'h77);
    chk("R9 no irq", h_irq_o, 0);
    host_rd(8'h04, 1'b0, rd);
    chk("R9 status kept", rd, 32'h0033_0122);
  endtask

  task automatic t_new_clears_err;
    host_wr(8'h00, 32'h0000_0100);
    host_rd(8'h04, 1'b0, rd);
    chk("R5 err cleared on accept", rd, 32'h0000_0101);
    ctl_done(1'b0, 8'h00);
    chk("R6 irq again", h_irq_o, 1);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset;
    t_payload;
    t_cmd;
    t_busy_ignore;
    t_resp;
    t_ack;
    t_err_noioc;
    t_idle_ignore;
    t_new_clears_err;
    repeat (2) @(negedge clk_i);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule